// File: doc/BRIEF.md
# Test Access Port Controller with Interconnect Integrity Instruction

This block is the serial test port controller for a chip whose boundary register holds two kinds of cells. Driver-side cells are ordinary boundary cells. Receiver-side cells also hold a sticky violation flag that is set by a delay sensor. The controller runs the usual sixteen-state test port machine from a clock, a mode-select line, a data-in line, an asynchronous reset and a data-out line. A four-bit instruction register selects one of three data paths: the one-bit bypass path, the external interconnect test, or an integrity variant of that test.

The integrity instruction uses the same boundary-register path as the external test. It adds only one level, `si_en`. That level tells the receiver cells to load their violation flags on capture in place of the pin value. No states are added to the machine; only the instruction decode differs. Capture, shift and update work the same way on every data scan. A test program can therefore read the flags after each pattern, after a group of patterns, or once at the end, all without reloading the instruction.

Top module: `tap_sitest_ctrl`

## Requirements
- R1: While `trst_n` is low, the controller is forced, without waiting for a clock, into the reset state with the bypass instruction: `bsr_mode`=0, `si_en`=0, `tdo_oe`=0 and `tdo`=0.
- R2: From any state, five consecutive `tck` rising edges with `tms`=1 bring the machine into the reset state, where `si_en` and `bsr_mode` read 0 whatever instruction was loaded.
- R3: In the instruction capture state, the instruction shift register loads the pattern 0001. During instruction shift, that pattern appears on `tdo` least significant bit first (1,0,0,0) while `tdi` enters at the most significant end.
- R4: Opcode 0000 selects the external test: `bsr_mode`=1 and `si_en`=0.
- R5: Opcode 0110 (parameter `SITEST_OP`) selects the integrity test: `bsr_mode`=1 and `si_en`=1. The new opcode takes effect only when the machine leaves the instruction update state; while the code is being shifted, and in the update state itself, the previous decode is held.
- R6: Opcode 1111, and any code other than 0000 or 0110, selects bypass: `bsr_mode`=0 and `si_en`=0. The data path is then one bit long. It captures 0, so the first bit shifted out is 0 and each later bit is the `tdi` bit from one shift earlier.
- R7: While the boundary register is selected, `bsr_capture` is high exactly in the data capture state, `bsr_shift` and `bsr_clk_en` exactly in the data shift state (`bsr_clk_en` also in capture), and `bsr_update` exactly in the data update state. With bypass selected, all four stay low.
- R8: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is 1 after a falling edge taken in the instruction shift or data shift state, and 0 after any other falling edge.
- R9: With the boundary register selected, each bit on `tdo` during data shift is the `bsr_so` value present at that falling edge. In bypass, `bsr_so` has no effect on `tdo`.
- R10: Data scans repeated under one loaded instruction return the boundary data each time, and `si_en` does not change during any data scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in |
| bsr_so | input | 1 | Serial output of the last boundary cell |
| tdo | output | 1 | Serial data out, falling-edge register |
| tdo_oe | output | 1 | Output enable for `tdo` |
| bsr_capture | output | 1 | Boundary capture strobe level |
| bsr_shift | output | 1 | Boundary shift select |
| bsr_clk_en | output | 1 | Boundary clock enable (capture or shift) |
| bsr_update | output | 1 | Boundary update strobe level |
| bsr_mode | output | 1 | Boundary cells isolate the core from the pins |
| si_en | output | 1 | Receiver cells capture violation flags |

## Verification
State-derived controls (`bsr_capture`, `bsr_shift`, `bsr_update`, `bsr_mode`, `si_en`) change at the rising edge that enters a state. The bench samples them 1 ns after that edge. A new opcode shows up one edge later than the update state is entered, and the bench checks both the held value and the new value at those two points. `tdo` and `tdo_oe` are registered on the falling edge, so each shift step samples them 1 ns after its falling edge. The bit read in shift step i is therefore due from the state and `bsr_so` values that held at that falling edge. The bench then drives the next `tms`/`tdi` values and waits for the rising edge.

// File: rtl/tap_sitest_ctrl.sv
module tap_sitest_ctrl #(
  parameter int IR_W = 4,
  parameter logic [IR_W-1:0] EXTEST_OP = '0,
  parameter logic [IR_W-1:0] SITEST_OP = 4'b0110
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  input  logic bsr_so,
  output logic tdo,
  output logic tdo_oe,
  output logic bsr_capture,
  output logic bsr_shift,
  output logic bsr_clk_en,
  output logic bsr_update,
  output logic bsr_mode,
  output logic si_en
);
  localparam logic [IR_W-1:0] BYPASS_OP = '1;
  localparam logic [IR_W-1:0] IR_CAP    = {{(IR_W-2){1'b0}}, 2'b01};

  typedef enum logic [3:0] {
    S_RESET, S_IDLE,
    S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PA_DR, S_EX2_DR, S_UP_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PA_IR, S_EX2_IR, S_UP_IR
  } tap_st_t;

  tap_st_t st, nxt;
  logic [IR_W-1:0] ir, ir_sr;
  logic byp;

  always_comb begin
    unique case (st)
      S_RESET:  nxt = tms ? S_RESET  : S_IDLE;
      S_IDLE:   nxt = tms ? S_SEL_DR : S_IDLE;
      S_SEL_DR: nxt = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: nxt = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  nxt = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: nxt = tms ? S_UP_DR  : S_PA_DR;
      S_PA_DR:  nxt = tms ? S_EX2_DR : S_PA_DR;
      S_EX2_DR: nxt = tms ? S_UP_DR  : S_SH_DR;
      S_UP_DR:  nxt = tms ? S_SEL_DR : S_IDLE;
      S_SEL_IR: nxt = tms ? S_RESET  : S_CAP_IR;
      S_CAP_IR: nxt = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  nxt = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: nxt = tms ? S_UP_IR  : S_PA_IR;
      S_PA_IR:  nxt = tms ? S_EX2_IR : S_PA_IR;
      S_EX2_IR: nxt = tms ? S_UP_IR  : S_SH_IR;
      S_UP_IR:  nxt = tms ? S_SEL_DR : S_IDLE;
      default:  nxt = S_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) st <= S_RESET;
    else         st <= nxt;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir    <= BYPASS_OP;
      ir_sr <= IR_CAP;
      byp   <= 1'b0;
    end else begin
      if (st == S_RESET)     ir <= BYPASS_OP;
      else if (st == S_UP_IR) ir <= ir_sr;
      if (st == S_CAP_IR)     ir_sr <= IR_CAP;
      else if (st == S_SH_IR) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
      if (st == S_CAP_DR)     byp <= 1'b0;
      else if (st == S_SH_DR) byp <= tdi;
    end
  end

  wire live    = (st != S_RESET);
  wire sel_bsr = live && ((ir == EXTEST_OP) || (ir == SITEST_OP));

  assign bsr_mode    = sel_bsr;
  assign si_en       = live && (ir == SITEST_OP);
  assign bsr_capture = sel_bsr && (st == S_CAP_DR);
  assign bsr_shift   = sel_bsr && (st == S_SH_DR);
  assign bsr_clk_en  = bsr_capture || bsr_shift;
  assign bsr_update  = sel_bsr && (st == S_UP_DR);

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (st == S_SH_IR) || (st == S_SH_DR);
      if (st == S_SH_IR)      tdo <= ir_sr[0];
      else if (st == S_SH_DR) tdo <= sel_bsr ? bsr_so : byp;
    end
  end
endmodule

// File: rtl/tap_sitest_chk.sv
module tap_sitest_chk (
  input logic tck,
  input logic trst_n,
  input logic tms,
  input logic tdo_oe,
  input logic bsr_capture,
  input logic bsr_shift,
  input logic bsr_mode,
  input logic si_en
);
  logic [2:0] ones;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)      ones <= '0;
    else if (!tms)    ones <= '0;
    else if (ones != 3'd7) ones <= ones + 3'd1;

  AST_TMS_RESET: assert property (@(posedge tck) disable iff (!trst_n)
    (ones >= 3'd5) |-> (!si_en && !bsr_mode)); // R2
  AST_SI_NEEDS_MODE: assert property (@(posedge tck) disable iff (!trst_n)
    si_en |-> bsr_mode); // R5
  AST_CAP_TO_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
    (bsr_capture && !tms) |=> bsr_shift); // R7
  AST_SHIFT_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    (bsr_shift && !tms) |=> bsr_shift); // R7
  AST_SHIFT_EXIT: assert property (@(posedge tck) disable iff (!trst_n)
    (bsr_shift && tms) |=> (!bsr_shift && !bsr_capture)); // R7
  AST_OE_OFF_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n)
    bsr_capture |-> !tdo_oe); // R8
  AST_SI_STABLE_SCAN: assert property (@(posedge tck) disable iff (!trst_n)
    bsr_shift |=> $stable(si_en)); // R10
endmodule

bind tap_sitest_ctrl tap_sitest_chk u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .tdo_oe(tdo_oe),
  .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
  .bsr_mode(bsr_mode), .si_en(si_en)
);

// File: tb/tap_sitest_ctrl_test.sv
module tap_sitest_ctrl_test;
  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, bsr_so = 1'b0;
  logic tdo, tdo_oe, bsr_capture, bsr_shift, bsr_clk_en, bsr_update, bsr_mode, si_en;
  int total = 0, bad = 0;

  tap_sitest_ctrl uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .bsr_so(bsr_so),
    .tdo(tdo), .tdo_oe(tdo_oe), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
    .bsr_clk_en(bsr_clk_en), .bsr_update(bsr_update), .bsr_mode(bsr_mode), .si_en(si_en)
  );

  always #4 tck = ~tck;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic d, output logic o, output logic oe);
    @(negedge tck); #1;
    o = tdo; oe = tdo_oe;
    tms = t; tdi = d;
    @(posedge tck); #1;
  endtask

  task automatic load_ir(input logic [3:0] code, output logic [3:0] cap,
                         output logic si_shift, output logic si_upd);
    logic o, oe;
    step(1, 0, o, oe); step(1, 0, o, oe); step(0, 0, o, oe); step(0, 0, o, oe);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, code[i], o, oe);
      cap[i] = o;
    end
    si_shift = si_en;
    step(1, 0, o, oe);
    si_upd = si_en;
    step(0, 0, o, oe);
  endtask

  task automatic scan_dr(input int n, input logic [7:0] din, input logic [7:0] bpat,
                         output logic [7:0] dout, output logic [3:0] fl, output logic oe_all);
    logic o, oe;
    dout = '0; oe_all = 1'b1;
    step(1, 0, o, oe);
    step(0, 0, o, oe); fl[0] = bsr_capture & bsr_clk_en;
    step(0, 0, o, oe); fl[1] = bsr_shift & bsr_clk_en;
    for (int i = 0; i < n; i++) begin
      bsr_so = bpat[i];
      step(i == n - 1, din[i], o, oe);
      dout[i] = o;
      oe_all &= oe;
    end
    step(1, 0, o, oe); fl[2] = bsr_update;
    step(0, 0, o, oe);
    step(0, 0, o, oe); fl[3] = oe;
  endtask

  task automatic t_reset;
    logic o, oe;
    trst_n = 1'b0; #1;
    chk({bsr_mode, si_en, tdo_oe, tdo} == 4'b0, "R1 async reset outputs", {bsr_mode, si_en, tdo_oe, tdo}, 0);
    @(negedge tck); trst_n = 1'b1;
    step(0, 0, o, oe);
    chk(!oe && !bsr_mode, "R8 idle oe low", oe, 0);
  endtask

  task automatic t_extest;
    logic [3:0] cap, fl; logic s1, s2, oea; logic [7:0] d;
    load_ir(4'b0000, cap, s1, s2);
    chk(cap == 4'b0001, "R3 ir capture pattern", cap, 4'b0001);
    chk(bsr_mode && !si_en, "R4 extest decode", {bsr_mode, si_en}, 2'b10);
    scan_dr(8, 8'h3C, 8'hA5, d, fl, oea);
    chk(d == 8'hA5, "R9 extest boundary data", d, 8'hA5);
    chk(fl[2:0] == 3'b111, "R7 extest strobes", fl[2:0], 3'b111);
    chk(oea && !fl[3], "R8 oe during and after shift", {oea, fl[3]}, 2'b10);
  endtask

  task automatic t_sitest;
    logic [3:0] cap, fl; logic s1, s2, oea; logic [7:0] d;
    logic [7:0] pats [3] = '{8'h81, 8'h00, 8'h5E};
    load_ir(4'b0110, cap, s1, s2);
    chk(!s1 && !s2, "R5 si held until update exit", {s1, s2}, 0);
    chk(si_en && bsr_mode, "R5 sitest decode", {bsr_mode, si_en}, 2'b11);
    for (int k = 0; k < 3; k++) begin
      scan_dr(8, 8'hFF, pats[k], d, fl, oea);
      chk(d == pats[k], "R10 repeated readout data", d, pats[k]);
      chk(si_en && fl[2:0] == 3'b111, "R10 si kept over scans", {si_en, fl[2:0]}, 4'hF);
    end
  endtask

  task automatic t_bypass(input logic [3:0] code, input string tag);
    logic [3:0] cap, fl; logic s1, s2, oea; logic [7:0] d;
    load_ir(code, cap, s1, s2);
    chk(!bsr_mode && !si_en, {tag, " bypass decode"}, {bsr_mode, si_en}, 0);
    scan_dr(6, 8'b0010_1101, 8'hFF, d, fl, oea);
    chk(d[5:0] == 6'b01_1010, {tag, " R9 one-bit path"}, d[5:0], 6'b01_1010);
    chk(fl[2:0] == 3'b000, "R7 strobes low in bypass", fl[2:0], 0);
  endtask

  task automatic t_tms_reset;
    logic [3:0] cap; logic s1, s2, o, oe;
    load_ir(4'b0110, cap, s1, s2);
    chk(si_en, "R2 precondition si set", si_en, 1);
    for (int i = 0; i < 5; i++) step(1, 0, o, oe);
    chk(!si_en && !bsr_mode, "R2 five tms ones reset", {bsr_mode, si_en}, 0);
    step(0, 0, o, oe);
    chk(!si_en && !bsr_mode, "R2 bypass kept after reset", {bsr_mode, si_en}, 0);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_extest();
    t_sitest();
    t_bypass(4'b1111, "R6 all-ones");
    t_bypass(4'b0101, "R6 unknown code");
    t_tms_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule